// File: doc/BRIEF.md
# Reloadable Up-Counter Timer Core

This block is a 32-bit up-counting timer driven through a simple word-addressed register port. The counter advances on a tick that is either every clock or a power-of-two division of the clock. It raises an overflow event when it steps past all ones and a compare event when it steps onto a programmed value. On overflow it either reloads from a load register and keeps going, or it parks at zero and clears its own start bit. Software can also force a reload at any time by writing a trigger register.

The overflow, compare and externally supplied capture events feed a three-bit sticky status register (write one to clear) behind an interrupt mask, and a separate wakeup mask turns the same events into a single-cycle wakeup pulse. The overflow and compare events also leave the block as one-cycle strobes for the neighbouring pin output and capture logic, which decodes its own fields from the control register.

Register word addresses: 0 control, 1 counter, 2 load, 3 trigger, 4 compare, 5 status, 6 interrupt mask, 7 wakeup mask, 8 system config. Writes land on the rising clock edge; reads are combinational from the current address.

Top module: `upcnt_timer`

## Requirements
- R1: After reset every register reads zero except system config (address 8), which reads 4 (posted flag, bit 2, set); irq and wakePulse are low.
- R2: With start (control bit 0) set and prescale enable (control bit 5) clear, the counter (address 1) gains exactly one per clock; with start clear it holds.
- R3: With prescale enable set, the counter gains one every 2^(p+1) clocks, p being control bits 4:2; the prescaler restarts from zero on any control write.
- R4: A counter write takes effect on its clock edge and overrides a tick in that cycle; the next tick continues from the written value.
- R5: When a tick finds the counter at all ones and auto-reload (control bit 1) is set, the counter takes the load register (address 2), keeps running, and ovfStrobe is high for the one cycle in which the new value is visible.
- R6: When that overflow happens with auto-reload clear, the counter becomes zero and control bit 0 reads back cleared.
- R7: Any write to the trigger register (address 3) copies the load register into the counter on that edge; reading address 3 returns all ones.
- R8: With compare enable (control bit 6) set, matchStrobe is high for one cycle when a tick has moved the counter onto the compare register (address 4); with compare enable clear it stays low.
- R9: Status (address 5) bit 0 is compare, bit 1 overflow, bit 2 capture (capEvt input); a bit becomes set only if the same bit of the interrupt mask (address 6) is set, and irq is high exactly while any status bit is set.
- R10: Writing a one to a status bit clears it; writing zero leaves it.
- R11: wakePulse is high for one cycle after any event whose wakeup mask (address 7) bit is set, regardless of the interrupt mask.
- R12: The masks store only bits 2:0; the control register stores bits 14:0 and reads them back unchanged.
- R13: Writing system config with bit 1 set returns every register and the counter to the R1 state; bit 2 of system config is otherwise a plain stored flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr |
| capEvt | input | 1 | One-cycle capture event from neighbouring logic |
| irq | output | 1 | Level interrupt, high while status is non-zero |
| wakePulse | output | 1 | One-cycle wakeup pulse |
| ovfStrobe | output | 1 | One-cycle overflow strobe |
| matchStrobe | output | 1 | One-cycle compare strobe |

## Verification
A wrong counter or prescaler state shows on the counter read port at the very next sample and grows with every tick, so it is caught by comparing against the tick count computed from elapsed cycles. A bad reload or stop decision appears in the cycle right after the overflow edge, both in the counter value and in the start bit read back, while a mis-set or stuck status bit shows on irq one cycle after the event or the clearing write. Random start values, prescale settings and run lengths sit beside directed runs at the all-ones boundary and the compare boundary.

// File: rtl/upcnt_timer_pkg.sv
package upcnt_timer_pkg;
  localparam int TMR_W  = 32;
  localparam int PTV_W  = 3;
  localparam int CTRL_W = 15;
  localparam int EVT_W  = 3;
  localparam int ADDR_W = 4;

  // event bit positions in status, interrupt mask and wakeup mask
  localparam int EV_MATCH = 0;
  localparam int EV_OVF   = 1;
  localparam int EV_CAP   = 2;

  // control bit positions used inside this block
  localparam int C_START = 0;
  localparam int C_AR    = 1;
  localparam int C_PTV   = 2;
  localparam int C_PRE   = 5;
  localparam int C_CE    = 6;

  // system config bit positions
  localparam int S_SRST   = 1;
  localparam int S_POSTED = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_COUNT  = 4'd1,
    A_LOAD   = 4'd2,
    A_TRIG   = 4'd3,
    A_MATCH  = 4'd4,
    A_STATUS = 4'd5,
    A_IRQEN  = 4'd6,
    A_WAKEEN = 4'd7,
    A_SYS    = 4'd8
  } regAddr_e;

  typedef struct packed {
    logic              softRst;
    logic              ctrlWr;
    logic              cntWr;
    logic              trigLoad;
    logic              start;
    logic              autoReload;
    logic              preEn;
    logic [PTV_W-1:0]  ptv;
    logic              cmpEn;
    logic [TMR_W-1:0]  wrVal;
    logic [TMR_W-1:0]  loadVal;
    logic [TMR_W-1:0]  matchVal;
  } dpCmd_t;

  typedef struct packed {
    logic              ovfNow;
    logic              matchNow;
    logic [TMR_W-1:0]  count;
  } dpStat_t;
endpackage

// File: rtl/upcnt_timer_dp.sv
module upcnt_timer_dp
  import upcnt_timer_pkg::*;
#(
  parameter int W  = TMR_W,
  parameter int PW = PTV_W
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpCmd_t  cmd,
  output dpStat_t stat,
  output logic    ovfStrobe,
  output logic    matchStrobe
);
  localparam int PSC_W = 1 << PW;

  logic [W-1:0]     countQ, countD, countInc;
  logic [PSC_W-1:0] pscQ, pscD, pscMask;
  logic [PW:0]      shAmt;
  logic             tick, atMax, override, ovfNow, matchNow;
  logic             ovfQ, matchQ;

  always_comb begin
    shAmt    = {1'b0, cmd.ptv} + {{PW{1'b0}}, 1'b1};
    pscMask  = ~({PSC_W{1'b1}} << shAmt);
    tick     = cmd.start & (~cmd.preEn | (pscQ == pscMask));
    atMax    = &countQ;
    countInc = countQ + W'(1);
    override = cmd.softRst | cmd.cntWr | cmd.trigLoad;
    ovfNow   = tick & atMax & ~override;
    matchNow = tick & cmd.cmpEn & ~atMax & ~override & (countInc == W'(cmd.matchVal));
  end

  always_comb begin
    countD = countQ;
    if (cmd.softRst)       countD = '0;
    else if (cmd.cntWr)    countD = W'(cmd.wrVal);
    else if (cmd.trigLoad) countD = W'(cmd.loadVal);
    else if (tick) begin
      if (atMax) countD = cmd.autoReload ? W'(cmd.loadVal) : '0;
      else       countD = countInc;
    end
  end

  always_comb begin
    if (cmd.softRst || cmd.ctrlWr || !cmd.start || !cmd.preEn) pscD = '0;
    else if (pscQ == pscMask)                                  pscD = '0;
    else                                                       pscD = pscQ + PSC_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
      pscQ   <= '0;
      ovfQ   <= 1'b0;
      matchQ <= 1'b0;
    end else begin
      countQ <= countD;
      pscQ   <= pscD;
      ovfQ   <= ovfNow;
      matchQ <= matchNow;
    end
  end

  assign stat.ovfNow   = ovfNow;
  assign stat.matchNow = matchNow;
  assign stat.count    = TMR_W'(countQ);
  assign ovfStrobe     = ovfQ;
  assign matchStrobe   = matchQ;
endmodule

// File: rtl/upcnt_timer_regs.sv
module upcnt_timer_regs
  import upcnt_timer_pkg::*;
#(
  parameter int W  = TMR_W,
  parameter int CW = CTRL_W,
  parameter int EW = EVT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData,
  input  logic          capEvt,
  input  dpStat_t       stat,
  output dpCmd_t        cmd,
  output logic          irq,
  output logic          wakePulse,
  output logic [EW-1:0] wakeEnOut
);
  logic [CW-1:0] ctrlQ;
  logic [W-1:0]  loadQ, matchQ;
  logic [EW-1:0] statusQ, irqEnQ, wakeEnQ, evtVec;
  logic          postedQ, wakeQ;
  logic          selCtrl, selCount, selLoad, selTrig, selMatch;
  logic          selStatus, selIrqEn, selWakeEn, selSys, softRst, stopReq;

  always_comb begin
    selCtrl   = wrEn && (addr == A_CTRL);
    selCount  = wrEn && (addr == A_COUNT);
    selLoad   = wrEn && (addr == A_LOAD);
    selTrig   = wrEn && (addr == A_TRIG);
    selMatch  = wrEn && (addr == A_MATCH);
    selStatus = wrEn && (addr == A_STATUS);
    selIrqEn  = wrEn && (addr == A_IRQEN);
    selWakeEn = wrEn && (addr == A_WAKEEN);
    selSys    = wrEn && (addr == A_SYS);
    softRst   = selSys && wrData[S_SRST];
    evtVec    = '0;
    evtVec[EV_MATCH] = stat.matchNow;
    evtVec[EV_OVF]   = stat.ovfNow;
    evtVec[EV_CAP]   = capEvt;
    stopReq   = stat.ovfNow && !ctrlQ[C_AR];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      loadQ   <= '0;
      matchQ  <= '0;
      statusQ <= '0;
      irqEnQ  <= '0;
      wakeEnQ <= '0;
      postedQ <= 1'b1;
      wakeQ   <= 1'b0;
    end else if (softRst) begin
      ctrlQ   <= '0;
      loadQ   <= '0;
      matchQ  <= '0;
      statusQ <= '0;
      irqEnQ  <= '0;
      wakeEnQ <= '0;
      postedQ <= 1'b1;
      wakeQ   <= 1'b0;
    end else begin
      if (selCtrl)      ctrlQ <= wrData[CW-1:0];
      else if (stopReq) ctrlQ[C_START] <= 1'b0;
      if (selLoad)   loadQ   <= wrData;
      if (selMatch)  matchQ  <= wrData;
      if (selIrqEn)  irqEnQ  <= wrData[EW-1:0];
      if (selWakeEn) wakeEnQ <= wrData[EW-1:0];
      if (selSys)    postedQ <= wrData[S_POSTED];
      // a new event wins over a clearing write in the same cycle
      statusQ <= (statusQ & ~(selStatus ? wrData[EW-1:0] : {EW{1'b0}}))
               | (evtVec & irqEnQ);
      wakeQ   <= |(evtVec & wakeEnQ);
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL:   rdData = W'(ctrlQ);
      A_COUNT:  rdData = W'(stat.count);
      A_LOAD:   rdData = loadQ;
      A_TRIG:   rdData = '1;
      A_MATCH:  rdData = matchQ;
      A_STATUS: rdData = W'(statusQ);
      A_IRQEN:  rdData = W'(irqEnQ);
      A_WAKEEN: rdData = W'(wakeEnQ);
      A_SYS:    rdData = W'({postedQ, 2'b00});
      default:  rdData = '0;
    endcase
  end

  always_comb begin
    cmd.softRst    = softRst;
    cmd.ctrlWr     = selCtrl;
    cmd.cntWr      = selCount;
    cmd.trigLoad   = selTrig;
    cmd.start      = ctrlQ[C_START];
    cmd.autoReload = ctrlQ[C_AR];
    cmd.preEn      = ctrlQ[C_PRE];
    cmd.ptv        = ctrlQ[C_PTV +: PTV_W];
    cmd.cmpEn      = ctrlQ[C_CE];
    cmd.wrVal      = TMR_W'(wrData);
    cmd.loadVal    = TMR_W'(loadQ);
    cmd.matchVal   = TMR_W'(matchQ);
  end

  assign irq       = |statusQ;
  assign wakePulse = wakeQ;
  assign wakeEnOut = wakeEnQ;
endmodule

// File: rtl/upcnt_timer.sv
module upcnt_timer
  import upcnt_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TMR_W-1:0]  wrData,
  output logic [TMR_W-1:0]  rdData,
  input  logic              capEvt,
  output logic              irq,
  output logic              wakePulse,
  output logic              ovfStrobe,
  output logic              matchStrobe
);
  dpCmd_t           cmd;
  dpStat_t          stat;
  logic [EVT_W-1:0] wakeEn;

  upcnt_timer_regs #(
    .W(TMR_W), .CW(CTRL_W), .EW(EVT_W), .AW(ADDR_W)
  ) i_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .capEvt(capEvt), .stat(stat), .cmd(cmd),
    .irq(irq), .wakePulse(wakePulse), .wakeEnOut(wakeEn)
  );

  upcnt_timer_dp #(
    .W(TMR_W), .PW(PTV_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .stat(stat),
    .ovfStrobe(ovfStrobe), .matchStrobe(matchStrobe)
  );
endmodule

// File: rtl/upcnt_timer_chk.sv
module upcnt_timer_chk
  import upcnt_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [TMR_W-1:0]  wrData,
  input logic              capEvt,
  input logic              irq,
  input logic              wakePulse,
  input logic              ovfStrobe,
  input logic              matchStrobe,
  input dpCmd_t            cmd,
  input dpStat_t           stat,
  input logic [EVT_W-1:0]  wakeEn
);
  logic [EVT_W-1:0] evtNow;
  assign evtNow = {capEvt, stat.ovfNow, stat.matchNow};

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.start && !cmd.preEn && !wrEn && !(&stat.count))
      |=> stat.count == $past(stat.count) + TMR_W'(1));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stat.ovfNow && cmd.autoReload && !wrEn)
      |=> (stat.count == $past(cmd.loadVal)) && ovfStrobe);

  p_stop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stat.ovfNow && !cmd.autoReload && !wrEn)
      |=> (stat.count == '0) && !cmd.start);

  p_match_ce_r8: assert property (@(posedge clk) disable iff (!rstN)
    matchStrobe |-> $past(cmd.cmpEn));

  p_irq_src_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(evtNow != '0));

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_STATUS && wrData[EVT_W-1:0] == '1 && evtNow == '0)
      |=> !irq);

  p_wake_cause_r11: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> $past((evtNow & wakeEn) != '0));
endmodule

bind upcnt_timer upcnt_timer_chk i_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .capEvt(capEvt), .irq(irq), .wakePulse(wakePulse), .ovfStrobe(ovfStrobe),
  .matchStrobe(matchStrobe), .cmd(cmd), .stat(stat), .wakeEn(wakeEn)
);

// File: tb/test_upcnt_timer.sv
`timescale 1ns/1ps
module test_upcnt_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wrData = 32'd0;
  logic        capEvt = 1'b0;
  logic [31:0] rdData;
  logic        irq, wakePulse, ovfStrobe, matchStrobe;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  upcnt_timer i_upcnt_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .capEvt(capEvt), .irq(irq), .wakePulse(wakePulse),
    .ovfStrobe(ovfStrobe), .matchStrobe(matchStrobe)
  );

  localparam logic [3:0] RC = 4'd0, RN = 4'd1, RL = 4'd2, RT = 4'd3, RM = 4'd4,
                         RS = 4'd5, RI = 4'd6, RW = 4'd7, RY = 4'd8;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdData;
  endtask

  function automatic logic [31:0] expCount(input logic [31:0] v, input int k,
                                           input bit pe, input int p);
    return v + (pe ? 32'(k >> (p + 1)) : 32'(k));
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d, v, l, m;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(RC, d); chk(d, 0, "R1 ctrl");
    rd(RN, d); chk(d, 0, "R1 count");
    rd(RS, d); chk(d, 0, "R1 status");
    rd(RY, d); chk(d, 32'd4, "R1 sysconfig");
    chk({31'd0, irq}, 0, "R1 irq");
    chk({31'd0, wakePulse}, 0, "R1 wake");

    // R12 mask and control storage
    wr(RI, 32'hFFFF_FFFF); rd(RI, d); chk(d, 32'd7, "R12 irq mask low bits");
    wr(RW, 32'hFFFF_FFF8); rd(RW, d); chk(d, 32'd0, "R12 wake mask low bits");
    wr(RC, 32'hFFFF_7FFE); rd(RC, d); chk(d, 32'h7FFE, "R12 ctrl readback");
    wr(RC, 0);
    wr(RI, 0);

    // R2 hold while stopped, then count per clock
    wr(RN, 32'd5);
    repeat (4) @(negedge clk);
    rd(RN, d); chk(d, 32'd5, "R2 hold when stopped");
    wr(RC, 32'h1);
    repeat (17) @(negedge clk);
    rd(RN, d); chk(d, 32'd22, "R2 count per clock");

    // R4 counter write while running
    v = $urandom & 32'h7FFF_FFFF;
    wr(RN, v);
    rd(RN, d); chk(d, v, "R4 write overrides tick");
    @(negedge clk);
    rd(RN, d); chk(d, v + 1, "R4 continue from written");

    // R3 prescale directed
    wr(RC, 0); wr(RN, 0);
    wr(RC, 32'h1 | (32'h1 << 5) | (32'd2 << 2));
    repeat (7) @(negedge clk);
    rd(RN, d); chk(d, 0, "R3 before first tick p=2");
    @(negedge clk);
    rd(RN, d); chk(d, 1, "R3 first tick p=2");

    // R2/R3 random runs
    for (int i = 0; i < 20; i++) begin
      bit pe; int p; int k;
      pe = 1'($urandom);
      p  = int'($urandom % 8);
      k  = 1 + int'($urandom % 600);
      v  = $urandom & 32'h7FFF_FFFF;
      wr(RC, 0); wr(RN, v);
      wr(RC, 32'h1 | (32'(pe) << 5) | (32'(p) << 2));
      repeat (k) @(negedge clk);
      rd(RN, d); chk(d, expCount(v, k, pe, p), pe ? "R3 random prescaled" : "R2 random");
    end

    // R5 overflow with reload, R9 overflow status
    wr(RC, 0);
    l = $urandom;
    wr(RL, l); wr(RI, 32'd2);
    wr(RN, 32'hFFFF_FFFD);
    wr(RC, 32'h3);
    repeat (2) @(negedge clk);
    chk({31'd0, ovfStrobe}, 0, "R5 no strobe before wrap");
    @(negedge clk);
    rd(RN, d); chk(d, l, "R5 reload value");
    chk({31'd0, ovfStrobe}, 1, "R5 overflow strobe");
    rd(RS, d); chk(d, 32'd2, "R9 overflow status");
    chk({31'd0, irq}, 1, "R9 irq high");
    rd(RC, d); chk(d & 1, 1, "R5 still running");
    @(negedge clk);
    chk({31'd0, ovfStrobe}, 0, "R5 strobe one cycle");
    rd(RN, d); chk(d, l + 1, "R5 keeps counting");

    // R10 write-one-to-clear
    wr(RC, 0);
    wr(RS, 32'd0); rd(RS, d); chk(d, 32'd2, "R10 zero write keeps");
    wr(RS, 32'd2); rd(RS, d); chk(d, 32'd0, "R10 one write clears");
    chk({31'd0, irq}, 0, "R10 irq low after clear");

    // R6 stop on overflow, R11 wake without interrupt, R9 masked
    wr(RI, 0); wr(RW, 32'd2);
    wr(RN, 32'hFFFF_FFFF);
    wr(RC, 32'h1);
    @(negedge clk);
    rd(RN, d); chk(d, 0, "R6 counter zero");
    rd(RC, d); chk(d & 1, 0, "R6 start cleared");
    chk({31'd0, wakePulse}, 1, "R11 wake pulse");
    rd(RS, d); chk(d, 0, "R9 masked status stays clear");
    chk({31'd0, irq}, 0, "R9 masked irq low");
    @(negedge clk);
    chk({31'd0, wakePulse}, 0, "R11 pulse one cycle");
    rd(RN, d); chk(d, 0, "R6 stays stopped");
    wr(RW, 0);

    // R8 compare enabled
    m = ($urandom & 32'h7FFF_FFFF) | 32'h10;
    wr(RI, 32'd1); wr(RM, m); wr(RN, m - 3);
    wr(RC, 32'h1 | (32'h1 << 6));
    repeat (2) @(negedge clk);
    chk({31'd0, matchStrobe}, 0, "R8 no early match");
    @(negedge clk);
    rd(RN, d); chk(d, m, "R8 counter at compare");
    chk({31'd0, matchStrobe}, 1, "R8 match strobe");
    rd(RS, d); chk(d, 32'd1, "R9 match status");
    @(negedge clk);
    chk({31'd0, matchStrobe}, 0, "R8 strobe one cycle");
    wr(RC, 0); wr(RS, 32'd7);

    // R8 compare disabled
    wr(RN, m - 3); wr(RC, 32'h1);
    repeat (3) @(negedge clk);
    chk({31'd0, matchStrobe}, 0, "R8 no match without enable");
    rd(RS, d); chk(d, 0, "R8 no status without enable");
    wr(RC, 0);

    // R7 trigger reload
    l = $urandom;
    wr(RL, l); wr(RC, 32'h1);
    wr(RT, $urandom);
    rd(RN, d); chk(d, l, "R7 trigger loads");
    rd(RT, d); chk(d, 32'hFFFF_FFFF, "R7 trigger reads ones");
    wr(RC, 0);

    // R9 capture status, R11 capture wake
    wr(RI, 32'd4); wr(RW, 32'd4);
    @(negedge clk); capEvt = 1'b1;
    @(negedge clk); capEvt = 1'b0;
    rd(RS, d); chk(d, 32'd4, "R9 capture status");
    chk({31'd0, wakePulse}, 1, "R11 capture wake");
    chk({31'd0, irq}, 1, "R9 capture irq");

    // R13 posted flag and soft reset
    wr(RY, 32'd0); rd(RY, d); chk(d, 0, "R13 posted flag stored");
    wr(RL, 32'h1234); wr(RN, 32'h55); wr(RC, 32'h41);
    wr(RY, 32'd2);
    rd(RC, d); chk(d, 0, "R13 ctrl cleared");
    rd(RN, d); chk(d, 0, "R13 counter cleared");
    rd(RL, d); chk(d, 0, "R13 load cleared");
    rd(RS, d); chk(d, 0, "R13 status cleared");
    rd(RI, d); chk(d, 0, "R13 irq mask cleared");
    rd(RY, d); chk(d, 32'd4, "R13 posted back to one");
    chk({31'd0, irq}, 0, "R13 irq low");

    summary();
    $finish;
  end
endmodule